// File: doc/BRIEF.md
# Three-Phase Zero-Crossing Delay Meter

This block times the gap between positive-going zero crossings of a three-phase power system. Each of three channels starts a counter on a crossing of its reference signal. The counter advances on a 256 kHz tick enable, so one count is 3.90625 µs. On the next crossing of the channel's target signal, the channel copies the count into its 16-bit unsigned result.

A 2-bit mode select decides which crossings pair up on each channel:
- In the voltage-to-current mode, each channel compares one phase's voltage with the same phase's current.
- In the other two modes, the channels compare phases against each other, using either the voltages or the currents.

A separate front end supplies the six crossing strobes, each one clock wide. The results feed power-factor and load-balance calculations elsewhere on the chip.

Top module: `zc_delay_meter`

## Requirements
- R1: While reset is held, and right after it is released, all three results read 0.
- R2: A result equals the number of clock cycles with `tickEn` high strictly after the reference strobe cycle and strictly before the target strobe cycle. It becomes visible on the clock edge that samples the target strobe. Strobe bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: With `modeSel` = 00, `delay0` uses A voltage to A current, `delay1` uses B voltage to B current, and `delay2` uses C voltage to C current.
- R4: With `modeSel` = 01, `delay0` uses A voltage to C voltage, `delay1` uses B voltage to C voltage, and `delay2` uses A voltage to B voltage.
- R5: With `modeSel` = 10, the pairs are the same as in R4 but taken from the current strobes.
- R6: `modeSel` = 11 pairs the strobes exactly like 00.
- R7: A target strobe on a channel with no measurement running has no effect, and a result changes only when a target strobe ends a running measurement.
- R8: A reference strobe during a running measurement restarts the count at 0. If the target strobe arrives in the same cycle, the old count is latched first and a new measurement then begins.
- R9: A count that reaches 0xFFFF stays there, and a latch taken after that point reads 0xFFFF.
- R10: In any cycle where `modeSel` differs from its value in the previous cycle (0 after reset), every running measurement is dropped, that cycle's strobes are ignored, and the results keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 256 kHz count enable, one cycle wide |
| modeSel | input | 2 | Pairing mode select |
| voltZc | input | 3 | Voltage positive zero-crossing strobes, bit 0 = A |
| currZc | input | 3 | Current positive zero-crossing strobes, bit 0 = A |
| delay0 | output | 16 | Channel 0 delay result |
| delay1 | output | 16 | Channel 1 delay result |
| delay2 | output | 16 | Channel 2 delay result |

## Verification
The hardest state to reach is saturation. It needs 65535 ticks after a reference crossing with no target crossing in between. The stimulus reaches it by arming every channel and then holding the tick high for about 70000 cycles before sending the targets. The next hardest cases are a strobe landing in the very cycle the mode changes, and a reference and target arriving together on a running channel. Dense random strobes, together with mode flips on random cycles, make these coincidences happen often, and a cycle-level reference model judges each one.

// File: rtl/zc_delay_pkg.sv
package zc_delay_pkg;
  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    MODE_VI  = 2'b00,
    MODE_VV  = 2'b01,
    MODE_II  = 2'b10,
    MODE_VI2 = 2'b11
  } modeT;

  typedef struct packed {
    logic [NUM_PH-1:0] start;
    logic [NUM_PH-1:0] stop;
    logic              flush;
    logic              tick;
  } ctrlT;
endpackage

// File: rtl/zc_delay_ctrl.sv
module zc_delay_ctrl
  import zc_delay_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [1:0]        modeSel,
  input  logic [NUM_PH-1:0] voltZc,
  input  logic [NUM_PH-1:0] currZc,
  output ctrlT              ctrl
);
  logic [1:0]        modeQ;
  logic [NUM_PH-1:0] refSel;
  logic [NUM_PH-1:0] tgtSel;
  logic [NUM_PH-1:0] phaseSrc;
  logic              modeChg;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= 2'b00;
    else       modeQ <= modeSel;
  end

  assign modeChg = (modeSel != modeQ);

  always_comb begin
    phaseSrc = (modeT'(modeSel) == MODE_II) ? currZc : voltZc;
    unique case (modeT'(modeSel))
      MODE_VV, MODE_II: begin
        refSel = {phaseSrc[0], phaseSrc[1], phaseSrc[0]};
        tgtSel = {phaseSrc[1], phaseSrc[2], phaseSrc[2]};
      end
      default: begin
        refSel = voltZc;
        tgtSel = currZc;
      end
    endcase
  end

  always_comb begin
    ctrl.flush = modeChg;
    ctrl.tick  = tickEn;
    ctrl.start = modeChg ? '0 : refSel;
    ctrl.stop  = modeChg ? '0 : tgtSel;
  end
endmodule

// File: rtl/zc_delay_dp.sv
module zc_delay_dp
  import zc_delay_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlT                         ctrl,
  output logic [NUM_PH-1:0]            armed,
  output logic [NUM_PH-1:0][CNT_W-1:0] cnt,
  output logic [NUM_PH-1:0][CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < NUM_PH; k++) begin : g_ch
    logic latch;
    assign latch = ctrl.stop[k] && armed[k];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        armed[k]  <= 1'b0;
        cnt[k]    <= '0;
        result[k] <= '0;
      end else if (ctrl.flush) begin
        armed[k] <= 1'b0;
        cnt[k]   <= '0;
      end else begin
        if (latch) result[k] <= cnt[k];
        if (ctrl.start[k]) begin
          armed[k] <= 1'b1;
          cnt[k]   <= '0;
        end else if (latch) begin
          armed[k] <= 1'b0;
        end else if (armed[k] && ctrl.tick && cnt[k] != CNT_MAX) begin
          cnt[k] <= cnt[k] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/zc_delay_meter.sv
module zc_delay_meter
  import zc_delay_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [1:0]       modeSel,
  input  logic [2:0]       voltZc,
  input  logic [2:0]       currZc,
  output logic [CNT_W-1:0] delay0,
  output logic [CNT_W-1:0] delay1,
  output logic [CNT_W-1:0] delay2
);
  ctrlT                         ctrl;
  logic [NUM_PH-1:0]            armed;
  logic [NUM_PH-1:0][CNT_W-1:0] cnt;
  logic [NUM_PH-1:0][CNT_W-1:0] result;

  zc_delay_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel),
    .voltZc(voltZc), .currZc(currZc), .ctrl(ctrl)
  );

  zc_delay_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .armed(armed), .cnt(cnt), .result(result)
  );

  assign delay0 = result[0];
  assign delay1 = result[1];
  assign delay2 = result[2];
endmodule

// File: rtl/zc_delay_meter_chk.sv
module zc_delay_meter_chk
  import zc_delay_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input ctrlT                         ctrl,
  input logic [NUM_PH-1:0]            armed,
  input logic [NUM_PH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_PH-1:0][CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R10: a mode change leaves every channel disarmed
  a_r10_flush_disarms: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flush |=> (armed == '0));

  for (genvar k = 0; k < NUM_PH; k++) begin : g_chk
    // R9: a full count never wraps while it keeps running
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (armed[k] && cnt[k] == CNT_MAX && !ctrl.start[k] && !ctrl.flush)
        |=> (cnt[k] == CNT_MAX));

    // R7: a result moves only on a latch
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(ctrl.stop[k] && armed[k]) |=> $stable(result[k]));

    // R8: a reference strobe always begins a fresh count
    a_r8_restart: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.start[k] && !ctrl.flush) |=> (armed[k] && cnt[k] == '0));

    // R2: an idle channel does not count
    a_r2_idle_still: assert property (@(posedge clk) disable iff (!rstN)
      (!armed[k] && !ctrl.start[k] && !ctrl.flush) |=> $stable(cnt[k]));
  end
endmodule

bind zc_delay_meter zc_delay_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrl(ctrl), .armed(armed), .cnt(cnt), .result(result)
);

// File: tb/zc_delay_meter_tb.sv
module zc_delay_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 65535;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [2:0]  voltZc = 3'b000;
  logic [2:0]  currZc = 3'b000;
  logic [15:0] delay0, delay1, delay2;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "R1";

  int mArmed[3];
  int mCnt[3];
  int mRes[3];
  int mPrevSel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zc_delay_meter u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel),
    .voltZc(voltZc), .currZc(currZc),
    .delay0(delay0), .delay1(delay1), .delay2(delay2)
  );

  function automatic int dutRes(input int k);
    if (k == 0) return int'(delay0);
    if (k == 1) return int'(delay1);
    return int'(delay2);
  endfunction

  task automatic check(input string tag, input int k, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s ch%0d got %0d expected %0d", tag, k, got, exp);
    end
  endtask

  task automatic compareAll();
    for (int k = 0; k < 3; k++) check(curTag, k, dutRes(k), mRes[k]);
  endtask

  // reference model: next state from the inputs the coming edge samples
  task automatic modelStep(input logic [2:0] v, input logic [2:0] c,
                           input logic t, input int s);
    int refB[3];
    int tgtB[3];
    bit flush;
    flush = (s != mPrevSel);
    mPrevSel = s;
    if (s == 1 || s == 2) begin
      logic [2:0] src;
      src = (s == 2) ? c : v;
      refB[0] = src[0]; tgtB[0] = src[2];
      refB[1] = src[1]; tgtB[1] = src[2];
      refB[2] = src[0]; tgtB[2] = src[1];
    end else begin
      for (int k = 0; k < 3; k++) begin refB[k] = v[k]; tgtB[k] = c[k]; end
    end
    for (int k = 0; k < 3; k++) begin
      if (flush) begin
        mArmed[k] = 0; mCnt[k] = 0;
      end else begin
        bit lat;
        lat = (tgtB[k] != 0) && (mArmed[k] != 0);
        if (lat) mRes[k] = mCnt[k];
        if (refB[k] != 0) begin mArmed[k] = 1; mCnt[k] = 0; end
        else if (lat) mArmed[k] = 0;
        else if (mArmed[k] != 0 && t && mCnt[k] < MAXV) mCnt[k]++;
      end
    end
  endtask

  task automatic drive(input logic [2:0] v, input logic [2:0] c,
                       input logic t, input logic [1:0] s);
    @(negedge clk);
    compareAll();
    voltZc = v; currZc = c; tickEn = t; modeSel = s;
    modelStep(v, c, t, int'(s));
  endtask

  task automatic randomRun(input int n, input int strobeOdds, input bit flipMode,
                           input logic [1:0] s);
    logic [1:0] cur;
    cur = s;
    for (int i = 0; i < n; i++) begin
      logic [2:0] v, c;
      for (int b = 0; b < 3; b++) begin
        v[b] = ($urandom % strobeOdds) == 0;
        c[b] = ($urandom % strobeOdds) == 0;
      end
      if (flipMode && ($urandom % 40) == 0) cur = 2'($urandom % 4);
      drive(v, c, 1'($urandom % 2), cur);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin mArmed[k] = 0; mCnt[k] = 0; mRes[k] = 0; end
    repeat (3) @(negedge clk);
    curTag = "R1";
    for (int k = 0; k < 3; k++) check("R1", k, dutRes(k), 0);
    rstN = 1'b1;
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    drive(3'b000, 3'b000, 1'b0, 2'b00);

    // R2: exact count of 100 ticks on every channel
    curTag = "R2";
    drive(3'b111, 3'b000, 1'b1, 2'b00);
    for (int i = 0; i < 100; i++) drive(3'b000, 3'b000, 1'b1, 2'b00);
    drive(3'b000, 3'b111, 1'b1, 2'b00);
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    for (int k = 0; k < 3; k++) check("R2", k, dutRes(k), 100);

    // R7: stray target strobes on idle channels
    curTag = "R7";
    for (int i = 0; i < 20; i++) drive(3'b000, 3'b111, 1'b1, 2'b00);
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    for (int k = 0; k < 3; k++) check("R7", k, dutRes(k), 100);

    curTag = "R3"; randomRun(3000, 25, 1'b0, 2'b00);
    curTag = "R4"; randomRun(3000, 25, 1'b0, 2'b01);
    curTag = "R5"; randomRun(3000, 25, 1'b0, 2'b10);
    curTag = "R6"; randomRun(3000, 25, 1'b0, 2'b11);
    curTag = "R8"; randomRun(3000, 3, 1'b0, 2'b00);
    curTag = "R10"; randomRun(6000, 8, 1'b1, 2'b01);

    // R9: saturation on all channels
    curTag = "R9";
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    drive(3'b111, 3'b000, 1'b1, 2'b00);
    for (int i = 0; i < 70000; i++) drive(3'b000, 3'b000, 1'b1, 2'b00);
    drive(3'b000, 3'b111, 1'b1, 2'b00);
    drive(3'b000, 3'b000, 1'b0, 2'b00);
    for (int k = 0; k < 3; k++) check("R9", k, dutRes(k), MAXV);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule